// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-based microcontroller core. On each accepted request it takes an operation select, the accumulator, a second operand, the B register and the incoming carry and auxiliary-carry bits. It returns a new accumulator value, a new B value, and new carry, auxiliary-carry and overflow bits. Each result carries its own write enable, so the surrounding core updates only what the operation defines.

Every operation except divide completes in a single registered step. Divide is a restoring shift-and-subtract engine that produces one quotient bit per clock. It keeps `busy` high while it runs and pulses `done` when it finishes. The core issues a request by raising `start` for one cycle while the unit is idle. Results, enables and `done` are valid together for exactly one cycle. Operand fetch, instruction decode and the register files belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: Operation select encoding: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 AND, 4 OR, 5 XOR, 6 increment, 7 decrement, 8 rotate left, 9 rotate left through carry, 10 rotate right, 11 rotate right through carry, 12 nibble swap, 13 decimal adjust, 14 multiply, 15 divide. A non-divide request accepted on a clock edge presents its results with `done` high after that same edge, for one cycle. All write enables are low whenever `done` is low.
- R2: Add and add-with-carry write the accumulator with the 8-bit sum. Add-with-carry also adds `cyIn`. Carry is set when the unsigned total exceeds 255. Auxiliary carry is set when the low-nibble total exceeds 15. Overflow is set when exactly one of the carries out of bit 6 and bit 7 occurs, which is the same as the signed total leaving -128..127. All three flags are written.
- R3: Subtract-with-borrow always subtracts both the operand and `cyIn`. Carry is set on a borrow out of bit 7 and auxiliary carry on a borrow out of bit 3. Overflow is set when exactly one of the borrows out of bit 6 and bit 7 occurs. All three flags are written.
- R4: AND, OR and XOR write only the accumulator, with the bitwise result, and write no flag.
- R5: Increment and decrement wrap between 0xFF and 0x00 and write no flag.
- R6: Plain rotates (left, right) circulate the end bit and write no flag. Rotate through carry moves bit 7 (left) or bit 0 (right) into carry and moves `cyIn` into the vacated bit. It writes the accumulator and carry only.
- R7: Nibble swap exchanges accumulator bits 3:0 with bits 7:4 and writes no flag.
- R8: Decimal adjust first adds 0x06 when the low nibble exceeds 9 or `acIn` is set. It then adds 0x60 when the high nibble of that sum exceeds 9, the first step carried out of bit 7, or `cyIn` is set. Carry is written set exactly when the second correction was applied, that is, when the decimal result exceeds 99.
- R9: Multiply writes the low product byte to the accumulator and the high byte to B. It clears carry and sets overflow exactly when the high byte is nonzero.
- R10: Divide with a nonzero divisor writes the quotient to the accumulator and the remainder to B, clears carry and clears overflow. `busy` is high for exactly 8 cycles after the accepting edge, and `done` follows on the edge that drops `busy`.
- R11: Divide by a zero B sets overflow and clears carry, with the same timing as R10. The accumulator and B values are then unspecified, although their write enables are still raised.
- R12: `start` asserted while `busy` is high is ignored. It produces no extra `done`, and the running divide returns its own correct result.
- R13: While `rst_n` is low, and after reset until the first request, `done`, `busy`, every write enable and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| opSel | input | 4 | Operation select (encoding in R1) |
| accIn | input | 8 | Current accumulator |
| opndIn | input | 8 | Second operand for add, subtract and logic operations |
| bIn | input | 8 | Current B register (multiplier or divisor) |
| cyIn | input | 1 | Current carry flag |
| acIn | input | 1 | Current auxiliary-carry flag |
| accOut | output | 8 | New accumulator value |
| accWe | output | 1 | Accumulator write enable |
| bOut | output | 8 | New B value |
| bWe | output | 1 | B write enable |
| cyOut | output | 1 | New carry flag |
| cyWe | output | 1 | Carry write enable |
| acOut | output | 1 | New auxiliary-carry flag |
| acWe | output | 1 | Auxiliary-carry write enable |
| ovOut | output | 1 | New overflow flag |
| ovWe | output | 1 | Overflow write enable |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest state to reach from the ports is a request that arrives while a divide is in flight. Such a request must leave no trace: no second `done`, and no change to the quotient and remainder already being built. The stimulus starts a divide, then holds `start` high with an add request and different operands over several of the busy cycles. The scoreboard holds only the divide's expected item, so any extra result pulse finds the queue empty and is reported. The edge cases of the flag rules are reached with chosen operands: signed overflow with and without carry, borrow out of the low nibble, decimal adjust with incoming carries, and a zero divisor.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DataW    = 8;
  localparam int NibW     = DataW / 2;
  localparam int OpW      = 4;
  localparam int DivSteps = DataW;
  localparam int CntW     = $clog2(DivSteps);

  typedef enum logic [OpW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_RL   = 4'd8,
    OP_RLC  = 4'd9,
    OP_RR   = 4'd10,
    OP_RRC  = 4'd11,
    OP_SWAP = 4'd12,
    OP_DA   = 4'd13,
    OP_MUL  = 4'd14,
    OP_DIV  = 4'd15
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;  // single-step operation accepted
    logic divInit;     // divide accepted, capture operands
    logic divStep;     // one quotient bit this cycle
    logic divLast;     // final quotient bit this cycle
  } ctrlStrobe_t;

  typedef struct packed {
    logic [DataW-1:0] acc;
    logic [DataW-1:0] b;
    logic             cy;
    logic             ac;
    logic             ov;
    logic             accWe;
    logic             bWe;
    logic             cyWe;
    logic             acWe;
    logic             ovWe;
  } aluResult_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  aluOp_e      opSel,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  typedef enum logic {S_IDLE, S_DIV} state_e;

  state_e          state;
  logic [CntW-1:0] stepCnt;

  always_comb begin
    strobe.loadResult = start && (state == S_IDLE) && (opSel != OP_DIV);
    strobe.divInit    = start && (state == S_IDLE) && (opSel == OP_DIV);
    strobe.divStep    = (state == S_DIV);
    strobe.divLast    = (state == S_DIV) && (stepCnt == CntW'(DivSteps - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.loadResult | strobe.divLast;
      if (strobe.divInit) begin
        state   <= S_DIV;
        stepCnt <= '0;
      end else if (strobe.divStep) begin
        stepCnt <= stepCnt + 1'b1;
        if (strobe.divLast) state <= S_IDLE;
      end
    end
  end

  assign busy = (state == S_DIV);

endmodule

// File: rtl/acc_alu_div.sv
module acc_alu_div
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [DataW-1:0] dividend,
  input  logic [DataW-1:0] divisor,
  output logic [DataW-1:0] quoNext,
  output logic [DataW-1:0] remNext,
  output logic             divZero
);

  logic [DataW-1:0] remR, quoR, dvsR;
  logic             zeroR;
  logic [DataW:0]   shifted;
  logic             fits;

  // Restoring step: bring down the next dividend bit, subtract if it fits
  always_comb begin
    shifted = {remR, quoR[DataW-1]};
    fits    = (shifted >= {1'b0, dvsR});
    remNext = fits ? (shifted[DataW-1:0] - dvsR) : shifted[DataW-1:0];
    quoNext = {quoR[DataW-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      zeroR <= 1'b0;
    end else if (init) begin
      remR  <= '0;
      quoR  <= dividend;
      dvsR  <= divisor;
      zeroR <= (divisor == '0);
    end else if (step) begin
      remR <= remNext;
      quoR <= quoNext;
    end
  end

  assign divZero = zeroR;

endmodule

// File: rtl/acc_alu_dpath.sv
module acc_alu_dpath
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  aluOp_e           opSel,
  input  logic [DataW-1:0] accIn,
  input  logic [DataW-1:0] opndIn,
  input  logic [DataW-1:0] bIn,
  input  logic             cyIn,
  input  logic             acIn,
  output aluResult_t       res
);

  logic             cin;
  logic [DataW:0]   sumFull, difFull;
  logic             sumC3, sumC6, difB3, difB6;
  logic             lowFix, hiFix;
  logic [DataW:0]   daStep;
  logic [DataW-1:0] daOut;
  logic [2*DataW-1:0] prod;
  aluResult_t       nxt;
  logic [DataW-1:0] quoNext, remNext;
  logic             divZero;

  assign cin = (opSel == OP_ADD) ? 1'b0 : cyIn;

  // Adder and subtractor; the carry or borrow into bit i is a^b^result at bit i
  always_comb begin
    sumFull = {1'b0, accIn} + {1'b0, opndIn} + {{DataW{1'b0}}, cin};
    difFull = {1'b0, accIn} - {1'b0, opndIn} - {{DataW{1'b0}}, cyIn};
    sumC3   = accIn[NibW]    ^ opndIn[NibW]    ^ sumFull[NibW];
    sumC6   = accIn[DataW-1] ^ opndIn[DataW-1] ^ sumFull[DataW-1];
    difB3   = accIn[NibW]    ^ opndIn[NibW]    ^ difFull[NibW];
    difB6   = accIn[DataW-1] ^ opndIn[DataW-1] ^ difFull[DataW-1];
  end

  // Decimal adjust as two chained corrections
  always_comb begin
    lowFix = (accIn[NibW-1:0] > NibW'(9)) || acIn;
    daStep = {1'b0, accIn} + (lowFix ? (DataW+1)'(6) : '0);
    hiFix  = (daStep[DataW-1:NibW] > NibW'(9)) || daStep[DataW] || cyIn;
    daOut  = daStep[DataW-1:0] + (hiFix ? DataW'(8'h60) : '0);
  end

  assign prod = accIn * bIn;

  always_comb begin
    nxt = '0;
    unique case (opSel)
      OP_ADD, OP_ADDC: begin
        nxt.acc = sumFull[DataW-1:0];
        nxt.cy  = sumFull[DataW];
        nxt.ac  = sumC3;
        nxt.ov  = sumC6 ^ sumFull[DataW];
        nxt.accWe = 1'b1; nxt.cyWe = 1'b1; nxt.acWe = 1'b1; nxt.ovWe = 1'b1;
      end
      OP_SUBB: begin
        nxt.acc = difFull[DataW-1:0];
        nxt.cy  = difFull[DataW];
        nxt.ac  = difB3;
        nxt.ov  = difB6 ^ difFull[DataW];
        nxt.accWe = 1'b1; nxt.cyWe = 1'b1; nxt.acWe = 1'b1; nxt.ovWe = 1'b1;
      end
      OP_AND:  begin nxt.acc = accIn & opndIn;  nxt.accWe = 1'b1; end
      OP_OR:   begin nxt.acc = accIn | opndIn;  nxt.accWe = 1'b1; end
      OP_XOR:  begin nxt.acc = accIn ^ opndIn;  nxt.accWe = 1'b1; end
      OP_INC:  begin nxt.acc = accIn + 1'b1;    nxt.accWe = 1'b1; end
      OP_DEC:  begin nxt.acc = accIn - 1'b1;    nxt.accWe = 1'b1; end
      OP_RL:   begin nxt.acc = {accIn[DataW-2:0], accIn[DataW-1]}; nxt.accWe = 1'b1; end
      OP_RR:   begin nxt.acc = {accIn[0], accIn[DataW-1:1]};       nxt.accWe = 1'b1; end
      OP_RLC: begin
        nxt.acc = {accIn[DataW-2:0], cyIn};
        nxt.cy  = accIn[DataW-1];
        nxt.accWe = 1'b1; nxt.cyWe = 1'b1;
      end
      OP_RRC: begin
        nxt.acc = {cyIn, accIn[DataW-1:1]};
        nxt.cy  = accIn[0];
        nxt.accWe = 1'b1; nxt.cyWe = 1'b1;
      end
      OP_SWAP: begin
        nxt.acc = {accIn[NibW-1:0], accIn[DataW-1:NibW]};
        nxt.accWe = 1'b1;
      end
      OP_DA: begin
        nxt.acc = daOut;
        nxt.cy  = hiFix;
        nxt.accWe = 1'b1; nxt.cyWe = 1'b1;
      end
      OP_MUL: begin
        nxt.acc = prod[DataW-1:0];
        nxt.b   = prod[2*DataW-1:DataW];
        nxt.cy  = 1'b0;
        nxt.ov  = (prod[2*DataW-1:DataW] != '0);
        nxt.accWe = 1'b1; nxt.bWe = 1'b1; nxt.cyWe = 1'b1; nxt.ovWe = 1'b1;
      end
      default: nxt = '0;
    endcase
  end

  acc_alu_div div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (strobe.divInit),
    .step     (strobe.divStep),
    .dividend (accIn),
    .divisor  (bIn),
    .quoNext  (quoNext),
    .remNext  (remNext),
    .divZero  (divZero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (strobe.loadResult) begin
      res <= nxt;
    end else if (strobe.divLast) begin
      res.acc   <= quoNext;
      res.b     <= remNext;
      res.cy    <= 1'b0;
      res.ov    <= divZero;
      res.accWe <= 1'b1;
      res.bWe   <= 1'b1;
      res.cyWe  <= 1'b1;
      res.acWe  <= 1'b0;
      res.ovWe  <= 1'b1;
    end else begin
      res.accWe <= 1'b0;
      res.bWe   <= 1'b0;
      res.cyWe  <= 1'b0;
      res.acWe  <= 1'b0;
      res.ovWe  <= 1'b0;
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OpW-1:0]   opSel,
  input  logic [DataW-1:0] accIn,
  input  logic [DataW-1:0] opndIn,
  input  logic [DataW-1:0] bIn,
  input  logic             cyIn,
  input  logic             acIn,
  output logic [DataW-1:0] accOut,
  output logic             accWe,
  output logic [DataW-1:0] bOut,
  output logic             bWe,
  output logic             cyOut,
  output logic             cyWe,
  output logic             acOut,
  output logic             acWe,
  output logic             ovOut,
  output logic             ovWe,
  output logic             busy,
  output logic             done
);

  aluOp_e      opTyped;
  ctrlStrobe_t strobe;
  aluResult_t  res;

  assign opTyped = aluOp_e'(opSel);

  acc_alu_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opSel  (opTyped),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  acc_alu_dpath dpath_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .opSel  (opTyped),
    .accIn  (accIn),
    .opndIn (opndIn),
    .bIn    (bIn),
    .cyIn   (cyIn),
    .acIn   (acIn),
    .res    (res)
  );

  assign accOut = res.acc;
  assign accWe  = res.accWe;
  assign bOut   = res.b;
  assign bWe    = res.bWe;
  assign cyOut  = res.cy;
  assign cyWe   = res.cyWe;
  assign acOut  = res.ac;
  assign acWe   = res.acWe;
  assign ovOut  = res.ov;
  assign ovWe   = res.ovWe;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OpW-1:0]   opSel,
  input logic             accMsb,
  input logic             cyIn,
  input logic             accOutLsb,
  input logic [DataW-1:0] bOut,
  input logic             cyOut,
  input logic             ovOut,
  input logic             accWe,
  input logic             bWe,
  input logic             cyWe,
  input logic             acWe,
  input logic             ovWe,
  input logic             busy,
  input logic             done
);

  logic [CntW:0] busyCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  assert_we_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(accWe || bWe || cyWe || acWe || ovWe));

  assert_logic_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy) && ($past(opSel) inside {OP_AND, OP_OR, OP_XOR}))
      |-> (accWe && !bWe && !cyWe && !acWe && !ovWe));

  assert_incdec_noflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy) && ($past(opSel) inside {OP_INC, OP_DEC}))
      |-> (accWe && !cyWe && !acWe && !ovWe));

  assert_rlc_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy) && ($past(opSel) == OP_RLC))
      |-> (cyWe && (cyOut == $past(accMsb)) && (accOutLsb == $past(cyIn))));

  assert_swap_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy) && ($past(opSel) == OP_SWAP))
      |-> (accWe && !cyWe && !acWe && !ovWe));

  assert_mul_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy) && bWe)
      |-> (cyWe && !cyOut && ovWe && (ovOut == (bOut != '0))));

  assert_div_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && (busyCnt == (CntW+1)'(DivSteps))));

  assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_div_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> (bWe && cyWe && !cyOut && ovWe));

  assert_no_start_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$fell(busy) && $past(busy)) |-> !done);

endmodule

bind acc_alu acc_alu_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .opSel     (opSel),
  .accMsb    (accIn[acc_alu_pkg::DataW-1]),
  .cyIn      (cyIn),
  .accOutLsb (accOut[0]),
  .bOut      (bOut),
  .cyOut     (cyOut),
  .ovOut     (ovOut),
  .accWe     (accWe),
  .bWe       (bWe),
  .cyWe      (cyWe),
  .acWe      (acWe),
  .ovWe      (ovWe),
  .busy      (busy),
  .done      (done)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  localparam int K_ADD = 0, K_ADDC = 1, K_SUBB = 2, K_AND = 3, K_OR = 4, K_XOR = 5,
                 K_INC = 6, K_DEC = 7, K_RL = 8, K_RLC = 9, K_RR = 10, K_RRC = 11,
                 K_SWAP = 12, K_DA = 13, K_MUL = 14, K_DIV = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] accIn = '0, opndIn = '0, bIn = '0;
  logic       cyIn = 1'b0, acIn = 1'b0;
  logic [7:0] accOut, bOut;
  logic       accWe, bWe, cyOut, cyWe, acOut, acWe, ovOut, ovWe, busy, done;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;

  typedef struct {
    int    acc;
    int    b;
    bit    cy, ac, ov;
    bit    accWe, bWe, cyWe, acWe, ovWe;
    bit    mask;
    int    lat;
    int    issueCyc;
    string tag;
  } exp_t;

  exp_t sbQ[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .accIn(accIn), .opndIn(opndIn), .bIn(bIn), .cyIn(cyIn), .acIn(acIn),
    .accOut(accOut), .accWe(accWe), .bOut(bOut), .bWe(bWe),
    .cyOut(cyOut), .cyWe(cyWe), .acOut(acOut), .acWe(acWe),
    .ovOut(ovOut), .ovWe(ovWe), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic exp_t model(input int op, input int a, input int o, input int b,
                                 input int c, input int ac, input string tag);
    exp_t e;
    int   t, r, v;
    e = '{acc:0, b:0, cy:0, ac:0, ov:0, accWe:0, bWe:0, cyWe:0, acWe:0, ovWe:0,
          mask:0, lat:1, issueCyc:0, tag:tag};
    case (op)
      K_ADD, K_ADDC: begin
        t = (op == K_ADDC) ? c : 0;
        r = a + o + t;
        e.acc = r & 255; e.cy = (r > 255);
        e.ac = (((a & 15) + (o & 15) + t) > 15);
        v = sgn(a) + sgn(o) + t; e.ov = (v > 127) || (v < -128);
        e.accWe = 1; e.cyWe = 1; e.acWe = 1; e.ovWe = 1;
      end
      K_SUBB: begin
        r = a - o - c;
        e.acc = r & 255; e.cy = (r < 0);
        e.ac = (((a & 15) - (o & 15) - c) < 0);
        v = sgn(a) - sgn(o) - c; e.ov = (v > 127) || (v < -128);
        e.accWe = 1; e.cyWe = 1; e.acWe = 1; e.ovWe = 1;
      end
      K_AND:  begin e.acc = a & o; e.accWe = 1; end
      K_OR:   begin e.acc = a | o; e.accWe = 1; end
      K_XOR:  begin e.acc = a ^ o; e.accWe = 1; end
      K_INC:  begin e.acc = (a + 1) % 256; e.accWe = 1; end
      K_DEC:  begin e.acc = (a + 255) % 256; e.accWe = 1; end
      K_RL:   begin e.acc = ((a * 2) % 256) + (a / 128); e.accWe = 1; end
      K_RR:   begin e.acc = (a / 2) + (a % 2) * 128; e.accWe = 1; end
      K_RLC:  begin e.acc = ((a * 2) % 256) + c; e.cy = (a >= 128); e.accWe = 1; e.cyWe = 1; end
      K_RRC:  begin e.acc = (a / 2) + c * 128; e.cy = (a % 2); e.accWe = 1; e.cyWe = 1; end
      K_SWAP: begin e.acc = (a % 16) * 16 + (a / 16); e.accWe = 1; end
      K_DA: begin
        v = a;
        if ((v % 16) > 9 || ac != 0) v = v + 6;
        e.cy = 0;
        if (((v / 16) % 16) > 9 || v > 255 || c != 0) begin v = v + 96; e.cy = 1; end
        e.acc = v % 256; e.accWe = 1; e.cyWe = 1;
      end
      K_MUL: begin
        r = a * b;
        e.acc = r % 256; e.b = r / 256; e.cy = 0; e.ov = (r > 255);
        e.accWe = 1; e.bWe = 1; e.cyWe = 1; e.ovWe = 1;
      end
      default: begin
        e.lat = 9; e.cy = 0;
        if (b == 0) begin e.mask = 1; e.ov = 1; end
        else begin e.acc = a / b; e.b = a % b; e.ov = 0; end
        e.accWe = 1; e.bWe = 1; e.cyWe = 1; e.ovWe = 1;
      end
    endcase
    return e;
  endfunction

  // Monitor: pops expectations when the design reports a result
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "R12", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        chk((cyc - e.issueCyc) == e.lat, {e.tag, " R1"}, "latency", cyc - e.issueCyc, e.lat);
        chk({accWe, bWe, cyWe, acWe, ovWe} == {e.accWe, e.bWe, e.cyWe, e.acWe, e.ovWe},
            e.tag, "write enables", {accWe, bWe, cyWe, acWe, ovWe},
            {e.accWe, e.bWe, e.cyWe, e.acWe, e.ovWe});
        if (e.accWe && !e.mask) chk(accOut == e.acc[7:0], e.tag, "acc", accOut, e.acc);
        if (e.bWe && !e.mask)   chk(bOut == e.b[7:0], e.tag, "b", bOut, e.b);
        if (e.cyWe) chk(cyOut == e.cy, e.tag, "carry", cyOut, e.cy);
        if (e.acWe) chk(acOut == e.ac, e.tag, "aux carry", acOut, e.ac);
        if (e.ovWe) chk(ovOut == e.ov, e.tag, "overflow", ovOut, e.ov);
      end
    end
  end

  task automatic issue(input int op, input int a, input int o, input int b,
                       input int c, input int ac, input string tag);
    exp_t e;
    e = model(op, a, o, b, c, ac, tag);
    e.issueCyc = cyc;
    sbQ.push_back(e);
    opSel = op[3:0]; accIn = a[7:0]; opndIn = o[7:0]; bIn = b[7:0];
    cyIn = c[0]; acIn = ac[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic divInterfered();
    exp_t e;
    e = model(K_DIV, 200, 0, 7, 0, 0, "R12");
    e.issueCyc = cyc;
    sbQ.push_back(e);
    opSel = 4'(K_DIV); accIn = 8'd200; bIn = 8'd7; cyIn = 1'b0; start = 1'b1;
    @(negedge clk);
    opSel = 4'(K_ADD); accIn = 8'h11; opndIn = 8'h22; bIn = 8'h00; cyIn = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R12", "extra done after divide", done, 0);
    chk(busy == 1'b0, "R12", "busy after divide", busy, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    chk({done, busy, accWe, bWe, cyWe, acWe, ovWe} == '0, "R13", "flags in reset",
        {done, busy, accWe, bWe, cyWe, acWe, ovWe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(accOut == 8'h00 && bOut == 8'h00, "R13", "data after reset", {accOut, bOut}, 0);
    chk(done == 1'b0 && busy == 1'b0, "R13", "done/busy after reset", {done, busy}, 0);

    // R2 add
    issue(K_ADD,  'h47, 'h38, 0, 1, 0, "R2");
    issue(K_ADD,  'h7F, 'h01, 0, 0, 0, "R2");
    issue(K_ADD,  'hFF, 'h01, 0, 0, 0, "R2");
    issue(K_ADDC, 'h99, 'h99, 0, 1, 0, "R2");
    issue(K_ADDC, 'h0F, 'h00, 0, 1, 0, "R2");
    issue(K_ADD,  'h80, 'h80, 0, 0, 0, "R2");
    // R3 subtract
    issue(K_SUBB, 'h10, 'h01, 0, 0, 0, "R3");
    issue(K_SUBB, 'h80, 'h01, 0, 0, 0, "R3");
    issue(K_SUBB, 'h00, 'h00, 0, 1, 0, "R3");
    issue(K_SUBB, 'h7F, 'hFF, 0, 0, 0, "R3");
    issue(K_SUBB, 'h55, 'h22, 0, 1, 0, "R3");
    // R4 logic
    issue(K_AND, 'hF0, 'h3C, 0, 1, 1, "R4");
    issue(K_OR,  'hF0, 'h3C, 0, 1, 1, "R4");
    issue(K_XOR, 'hF0, 'h3C, 0, 1, 1, "R4");
    // R5 increment and decrement
    issue(K_INC, 'hFF, 0, 0, 0, 0, "R5");
    issue(K_DEC, 'h00, 0, 0, 1, 0, "R5");
    issue(K_INC, 'h7F, 0, 0, 0, 0, "R5");
    // R6 rotates
    issue(K_RL,  'h81, 0, 0, 0, 0, "R6");
    issue(K_RR,  'h01, 0, 0, 1, 0, "R6");
    issue(K_RLC, 'h80, 0, 0, 0, 0, "R6");
    issue(K_RLC, 'h01, 0, 0, 1, 0, "R6");
    issue(K_RRC, 'h01, 0, 0, 1, 0, "R6");
    issue(K_RRC, 'h80, 0, 0, 0, 0, "R6");
    // R7 swap
    issue(K_SWAP, 'hA5, 0, 0, 1, 1, "R7");
    // R8 decimal adjust
    issue(K_DA, 'h9A, 0, 0, 0, 0, "R8");
    issue(K_DA, 'h32, 0, 0, 1, 1, "R8");
    issue(K_DA, 'h85, 0, 0, 0, 0, "R8");
    issue(K_DA, 'h0F, 0, 0, 0, 0, "R8");
    issue(K_DA, 'hA0, 0, 0, 0, 0, "R8");
    // R9 multiply
    issue(K_MUL, 'h10, 0, 'h10, 0, 0, "R9");
    issue(K_MUL, 'h0F, 0, 'h0F, 1, 0, "R9");
    issue(K_MUL, 'hFF, 0, 'hFF, 0, 0, "R9");
    // R10 divide
    issue(K_DIV, 'hFB, 0, 'h0A, 1, 0, "R10");
    issue(K_DIV, 'h07, 0, 'h09, 0, 0, "R10");
    issue(K_DIV, 'hFF, 0, 'h01, 0, 0, "R10");
    issue(K_DIV, 'h00, 0, 'h05, 0, 0, "R10");
    issue(K_DIV, 'hFF, 0, 'hFF, 0, 0, "R10");
    // R11 divide by zero
    issue(K_DIV, 'h55, 0, 'h00, 1, 0, "R11");
    issue(K_DIV, 'h00, 0, 'h00, 0, 0, "R11");
    // R12 request during a running divide
    divInterfered();
    // Mixed sweep
    for (int i = 0; i < 16; i++) begin
      issue(i, (i * 37 + 11) % 256, (i * 91 + 5) % 256, (i * 13 + 3) % 256,
            i % 2, (i / 2) % 2, "R1");
    end

    chk(sbQ.size() == 0, "R1", "pending expectations", sbQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule